// File: doc/BRIEF.md
# Log-Domain Viterbi Scoring Engine

This block rates how well a stream of quantized hand-motion directions fits one discrete hidden Markov gesture model. Every probability it handles is already a logarithm, so each product in the Viterbi recursion becomes a saturating addition. The winning score is chosen by a plain signed compare, because taking logarithms does not change which value is largest. The alphabet is the sixteen orientation codes. The model has up to eight states.

Software first writes the model through a parameter port. Each value is a 16-bit signed log-probability. The most negative code, -32768, means "impossible". Direction symbols then arrive one at a time with a valid and a last flag. For each symbol the engine updates one destination state per clock, and it refuses new symbols while it is working. After the symbol flagged last, it presents the 24-bit path metric of the chosen final state for one cycle. Loading from external memory and any conversion into or out of the log domain are done elsewhere.

Top module: `vit_score_engine`

## Requirements
- R1: After reset, `busy` and `score_valid` are low and `sym_ready` is high. All model entries read as impossible (-32768), and all path metrics hold the metric sentinel -8388608.
- R2: When idle, a cycle with `prm_we` high stores `prm_val` into the entry selected by `prm_kind`. Kind 0 is the start log-probability of state `prm_row`. Kind 1 is the transition log-probability from state `prm_row` to state `prm_col` (ignored when `prm_col` >= 8). Kind 2 is the emission log-probability of symbol `prm_col` in state `prm_row`. Kind 3 writes nothing.
- R3: For the first symbol of a sequence, state j receives start[j] + emit[j][symbol].
- R4: For every later symbol, state j receives max over i of (metric[i] + trans[i][j]), plus emit[j][symbol]. All of these terms use the metrics from before this symbol.
- R5: An addition with an impossible operand (log value -32768 or metric -8388608) gives the metric sentinel -8388608. A state with no possible path therefore scores -8388608.
- R6: Path metrics are 24-bit signed and saturate instead of wrapping. Sums below -8388608 become -8388608, and sums above 8388607 become 8388607.
- R7: A symbol is accepted on a clock edge where `sym_valid` and `sym_ready` are both high. `busy` is then high, and `sym_ready` low, for exactly 8 cycles. A symbol presented during that time is ignored.
- R8: On the edge where the update of a last symbol completes, `score_valid` pulses high for one cycle. In that cycle `score` carries the new metric of the final state. The final state is the value of `fin_state` that was captured when the last symbol was accepted.
- R9: The symbol after a last symbol starts a new sequence and uses the start log-probabilities (R3).
- R10: Parameter writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prm_we | input | 1 | Parameter write strobe |
| prm_kind | input | 2 | Entry class: 0 start, 1 transition, 2 emission, 3 none |
| prm_row | input | 3 | State index (source state for transitions) |
| prm_col | input | 4 | Destination state or symbol index |
| prm_val | input | 16 | Signed log-probability to store |
| sym_valid | input | 1 | Symbol offered |
| sym_ready | output | 1 | Engine can take a symbol |
| sym_data | input | 4 | Orientation symbol |
| sym_last | input | 1 | Symbol ends the sequence |
| fin_state | input | 3 | State whose metric becomes the score |
| busy | output | 1 | State update in progress |
| score_valid | output | 1 | One-cycle score strobe |
| score | output | 24 | Signed best path metric of the final state |

## Verification
The hardest conditions to create from the ports are saturation at either end of the 24-bit metric range, and stray writes or symbols that arrive in the middle of an update. The model is loaded with constant log values near the 16-bit limits. Sequences of 150 symbols then drive the metric into each clamp, and the score is compared against the exact limit. For interference, one symbol and one emission write are injected during a busy window. The write targets the entry that the final score depends on, so if it were accepted the score would change. Random models, including some impossible entries, and random sequences of random length are checked against an integer reference model in the bench.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int LP_W = 16;
  localparam int PM_W = 24;

  typedef logic signed [LP_W-1:0] lp_t;
  typedef logic signed [PM_W-1:0] pm_t;

  localparam lp_t LP_NEG = {1'b1, {(LP_W-1){1'b0}}};
  localparam pm_t PM_NEG = {1'b1, {(PM_W-1){1'b0}}};
  localparam pm_t PM_TOP = {1'b0, {(PM_W-1){1'b1}}};

  typedef enum logic [1:0] {
    PK_INIT  = 2'd0,
    PK_TRANS = 2'd1,
    PK_OBS   = 2'd2,
    PK_NONE  = 2'd3
  } pkind_e;

  // Widen a log value to a metric; the impossible code maps to the metric sentinel.
  function automatic pm_t lp_widen(lp_t v);
    if (v == LP_NEG) return PM_NEG;
    return {{(PM_W-LP_W){v[LP_W-1]}}, v};
  endfunction

  // Log-domain product: saturating add, the sentinel absorbs.
  function automatic pm_t pm_add(pm_t m, lp_t l);
    logic signed [PM_W:0] s;
    logic signed [PM_W:0] lo;
    logic signed [PM_W:0] hi;
    if (m == PM_NEG || l == LP_NEG) return PM_NEG;
    lo = {PM_NEG[PM_W-1], PM_NEG};
    hi = {PM_TOP[PM_W-1], PM_TOP};
    s  = {m[PM_W-1], m} + {{(PM_W-LP_W+1){l[LP_W-1]}}, l};
    if (s < lo) return PM_NEG;
    if (s > hi) return PM_TOP;
    return s[PM_W-1:0];
  endfunction
endpackage

// File: rtl/vit_param_store.sv
module vit_param_store
  import vit_pkg::*;
#(
  parameter int NS = 8,
  parameter int NO = 16,
  localparam int SW = $clog2(NS),
  localparam int OW = $clog2(NO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_row,
  input  logic [OW-1:0] wr_col,
  input  lp_t           wr_val,
  input  logic [SW-1:0] rd_dst,
  input  logic [OW-1:0] rd_sym,
  output lp_t           rd_init,
  output lp_t           rd_col [NS],
  output lp_t           rd_obs
);
  lp_t init_q  [NS];
  lp_t trans_q [NS][NS];
  lp_t obs_q   [NS][NO];

  logic row_ok;
  logic col_is_state;
  assign row_ok       = int'(wr_row) < NS;
  assign col_is_state = int'(wr_col) < NS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NS; r++) begin
        init_q[r] <= LP_NEG;
        for (int c = 0; c < NS; c++) trans_q[r][c] <= LP_NEG;
        for (int c = 0; c < NO; c++) obs_q[r][c]   <= LP_NEG;
      end
    end else if (wr_en && row_ok) begin
      case (wr_kind)
        PK_INIT:  init_q[wr_row] <= wr_val;
        PK_TRANS: if (col_is_state) trans_q[wr_row][wr_col[SW-1:0]] <= wr_val;
        PK_OBS:   obs_q[wr_row][wr_col] <= wr_val;
        default:  ;
      endcase
    end
  end

  assign rd_init = init_q[rd_dst];
  assign rd_obs  = obs_q[rd_dst][rd_sym];

  for (genvar g = 0; g < NS; g++) begin : g_col
    assign rd_col[g] = trans_q[g][rd_dst];
  end
endmodule

// File: rtl/vit_acs.sv
module vit_acs
  import vit_pkg::*;
#(
  parameter int NS = 8,
  localparam int SW = $clog2(NS)
) (
  input  logic          first,
  input  pm_t           metric_in [NS],
  input  lp_t           col_lp    [NS],
  input  lp_t           init_lp,
  input  lp_t           obs_lp,
  output pm_t           new_metric,
  output logic [SW-1:0] best_src,
  output pm_t           pred_metric
);
  pm_t cand [NS];
  pm_t best;

  for (genvar g = 0; g < NS; g++) begin : g_cand
    assign cand[g] = pm_add(metric_in[g], col_lp[g]);
  end

  // Strictly greater replaces, so ties keep the lower source index.
  always_comb begin
    best     = cand[0];
    best_src = '0;
    for (int i = 1; i < NS; i++) begin
      if (cand[i] > best) begin
        best     = cand[i];
        best_src = SW'(i);
      end
    end
  end

  assign pred_metric = first ? lp_widen(init_lp) : best;
  assign new_metric  = pm_add(pred_metric, obs_lp);
endmodule

// File: rtl/vit_seq.sv
module vit_seq #(
  parameter int NS = 8,
  parameter int NO = 16,
  localparam int SW = $clog2(NS),
  localparam int OW = $clog2(NO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_valid,
  input  logic [OW-1:0] sym_data,
  input  logic          sym_last,
  input  logic [SW-1:0] fin_state,
  output logic          busy,
  output logic          accept,
  output logic          last_step,
  output logic [SW-1:0] dst,
  output logic [OW-1:0] sym_q,
  output logic          first_q,
  output logic          last_q,
  output logic [SW-1:0] fin_q
);
  assign accept    = sym_valid && !busy;
  assign last_step = busy && (dst == SW'(NS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      dst     <= '0;
      sym_q   <= '0;
      first_q <= 1'b1;
      last_q  <= 1'b0;
      fin_q   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      dst    <= '0;
      sym_q  <= sym_data;
      last_q <= sym_last;
      fin_q  <= fin_state;
    end else if (busy) begin
      if (last_step) begin
        busy    <= 1'b0;
        first_q <= last_q;
      end else begin
        dst <= dst + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vit_score_engine.sv
module vit_score_engine
  import vit_pkg::*;
#(
  parameter int N_STATES = 8,
  parameter int N_SYMS   = 16,
  localparam int ST_W = $clog2(N_STATES),
  localparam int SY_W = $clog2(N_SYMS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prm_we,
  input  logic [1:0]               prm_kind,
  input  logic [ST_W-1:0]          prm_row,
  input  logic [SY_W-1:0]          prm_col,
  input  logic signed [LP_W-1:0]   prm_val,
  input  logic                     sym_valid,
  output logic                     sym_ready,
  input  logic [SY_W-1:0]          sym_data,
  input  logic                     sym_last,
  input  logic [ST_W-1:0]          fin_state,
  output logic                     busy,
  output logic                     score_valid,
  output logic signed [PM_W-1:0]   score
);
  // Named internal events
  logic            busy_w;
  logic            accept_evt;
  logic            last_step;
  logic            prm_we_eff;
  logic [ST_W-1:0] dst_w;
  logic [SY_W-1:0] sym_q;
  logic            first_q;
  logic            last_q;
  logic [ST_W-1:0] fin_q;
  lp_t             init_lp_w;
  lp_t             obs_lp_w;
  lp_t             col_lp_w [N_STATES];
  pm_t             acs_new;
  pm_t             acs_pred;
  logic [ST_W-1:0] acs_src;

  pm_t metric_q    [N_STATES];
  pm_t staged_q    [N_STATES];
  pm_t commit_view [N_STATES];
  logic score_valid_q;
  pm_t  score_q;

  assign prm_we_eff = prm_we && !busy_w;

  vit_seq #(.NS(N_STATES), .NO(N_SYMS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .sym_last  (sym_last),
    .fin_state (fin_state),
    .busy      (busy_w),
    .accept    (accept_evt),
    .last_step (last_step),
    .dst       (dst_w),
    .sym_q     (sym_q),
    .first_q   (first_q),
    .last_q    (last_q),
    .fin_q     (fin_q)
  );

  vit_param_store #(.NS(N_STATES), .NO(N_SYMS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prm_we_eff),
    .wr_kind (prm_kind),
    .wr_row  (prm_row),
    .wr_col  (prm_col),
    .wr_val  (prm_val),
    .rd_dst  (dst_w),
    .rd_sym  (sym_q),
    .rd_init (init_lp_w),
    .rd_col  (col_lp_w),
    .rd_obs  (obs_lp_w)
  );

  vit_acs #(.NS(N_STATES)) u_acs (
    .first       (first_q),
    .metric_in   (metric_q),
    .col_lp      (col_lp_w),
    .init_lp     (init_lp_w),
    .obs_lp      (obs_lp_w),
    .new_metric  (acs_new),
    .best_src    (acs_src),
    .pred_metric (acs_pred)
  );

  for (genvar k = 0; k < N_STATES; k++) begin : g_view
    assign commit_view[k] = (dst_w == ST_W'(k)) ? acs_new : staged_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_STATES; k++) begin
        metric_q[k] <= PM_NEG;
        staged_q[k] <= PM_NEG;
      end
      score_valid_q <= 1'b0;
      score_q       <= '0;
    end else begin
      score_valid_q <= 1'b0;
      if (busy_w) staged_q[dst_w] <= acs_new;
      if (last_step) begin
        for (int k = 0; k < N_STATES; k++) metric_q[k] <= commit_view[k];
        if (last_q) begin
          score_valid_q <= 1'b1;
          score_q       <= commit_view[fin_q];
        end
      end
    end
  end

  assign busy        = busy_w;
  assign sym_ready   = !busy_w;
  assign score_valid = score_valid_q;
  assign score       = score_q;
endmodule

// File: rtl/vit_score_engine_chk.sv
module vit_score_engine_chk
  import vit_pkg::*;
#(
  parameter int NS = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sym_valid,
  input logic          sym_ready,
  input logic          score_valid,
  input logic [SW-1:0] dst,
  input lp_t           obs_lp,
  input pm_t           new_metric
);
  int busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (sym_valid && sym_ready) busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == NS); // R7
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (busy && dst == '0)); // R7
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> dst == SW'($past(dst) + 1)); // R4
  AST_SCORE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid |-> $fell(busy)); // R8
  AST_SCORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid |=> !score_valid); // R8
  AST_IMPOSSIBLE_OBS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && obs_lp == LP_NEG) |-> new_metric == PM_NEG); // R5
endmodule

bind vit_score_engine vit_score_engine_chk #(.NS(N_STATES), .SW(ST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy_w),
  .sym_valid   (sym_valid),
  .sym_ready   (sym_ready),
  .score_valid (score_valid),
  .dst         (dst_w),
  .obs_lp      (obs_lp_w),
  .new_metric  (acs_new)
);

// File: tb/vit_score_engine_bench.sv
module vit_score_engine_bench;
  localparam int NS = 8;
  localparam int NO = 16;
  localparam int LPMIN = -32768;
  localparam int PMIN  = -8388608;
  localparam int PMAX  = 8388607;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prm_we = 1'b0;
  logic [1:0] prm_kind = 2'd0;
  logic [2:0] prm_row = 3'd0;
  logic [3:0] prm_col = 4'd0;
  logic signed [15:0] prm_val = 16'sd0;
  logic sym_valid = 1'b0;
  logic sym_ready;
  logic [3:0] sym_data = 4'd0;
  logic sym_last = 1'b0;
  logic [2:0] fin_state = 3'd0;
  logic busy;
  logic score_valid;
  logic signed [23:0] score;

  always #10 clk = ~clk;

  vit_score_engine u_vit_score_engine (
    .clk(clk), .rst_n(rst_n), .prm_we(prm_we), .prm_kind(prm_kind),
    .prm_row(prm_row), .prm_col(prm_col), .prm_val(prm_val),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .sym_last(sym_last), .fin_state(fin_state), .busy(busy),
    .score_valid(score_valid), .score(score)
  );

  int checks = 0;
  int fails = 0;

  int r_init [NS];
  int r_tr   [NS][NS];
  int r_ob   [NS][NO];
  int r_m    [NS];
  bit r_first = 1'b1;

  function automatic int ref_add(int m, int l);
    int s;
    if (m == PMIN || l == LPMIN) return PMIN;
    s = m + l;
    if (s < PMIN) return PMIN;
    if (s > PMAX) return PMAX;
    return s;
  endfunction

  function automatic void ref_step(int s);
    int nm [NS];
    for (int j = 0; j < NS; j++) begin
      int p;
      if (r_first) p = (r_init[j] == LPMIN) ? PMIN : r_init[j];
      else begin
        p = PMIN;
        for (int i = 0; i < NS; i++) begin
          int c = ref_add(r_m[i], r_tr[i][j]);
          if (c > p) p = c;
        end
      end
      nm[j] = ref_add(p, r_ob[j][s]);
    end
    for (int j = 0; j < NS; j++) r_m[j] = nm[j];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int row, input int col, input int val);
    @(negedge clk);
    prm_we = 1'b1; prm_kind = 2'(kind); prm_row = 3'(row);
    prm_col = 4'(col); prm_val = 16'(val);
    @(negedge clk);
    prm_we = 1'b0;
    case (kind)
      0: r_init[row] = val;
      1: if (col < NS) r_tr[row][col] = val;
      2: r_ob[row][col] = val;
      default: ;
    endcase
  endtask

  function automatic int rnd_lp();
    if ($urandom_range(0, 11) == 0) return LPMIN;
    return -int'($urandom_range(0, 3000));
  endfunction

  task automatic load_model(input bit rnd, input int cval);
    for (int r = 0; r < NS; r++) begin
      wr(0, r, 0, rnd ? rnd_lp() : cval);
      for (int c = 0; c < NS; c++) wr(1, r, c, rnd ? rnd_lp() : cval);
      for (int c = 0; c < NO; c++) wr(2, r, c, rnd ? rnd_lp() : cval);
    end
  endtask

  // Offer one symbol and follow the busy window; inject noise on request.
  task automatic run_sym(input int s, input bit last, input int fin,
                         input bit noise, input bit chk, input string req);
    @(negedge clk);
    sym_valid = 1'b1; sym_data = 4'(s); sym_last = last; fin_state = 3'(fin);
    @(negedge clk);
    sym_valid = 1'b0;
    ref_step(s);
    if (chk) begin
      check(busy == 1'b1, "R7", int'(busy), 1);
      check(sym_ready == 1'b0, "R7", int'(sym_ready), 0);
    end
    if (noise) begin
      sym_valid = 1'b1; sym_data = 4'((s + 3) % NO); sym_last = 1'b1;
      fin_state = 3'((fin + 1) % NS);
      prm_we = 1'b1; prm_kind = 2'd2; prm_row = 3'(fin);
      prm_col = 4'(s); prm_val = 16'sd0;
    end
    for (int k = 0; k < NS - 1; k++) begin
      @(negedge clk);
      sym_valid = 1'b0; prm_we = 1'b0;
    end
    if (chk) check(busy == 1'b1, "R7", int'(busy), 1);
    @(negedge clk);
    if (chk) begin
      check(busy == 1'b0, "R7", int'(busy), 0);
      check(score_valid == last, "R8", int'(score_valid), int'(last));
    end
    if (last) check(int'(score) == r_m[fin], req, int'(score), r_m[fin]);
    r_first = last;
  endtask

  initial begin
    repeat (2000000 / 10) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NS; r++) begin
      r_init[r] = LPMIN; r_m[r] = PMIN;
      for (int c = 0; c < NS; c++) r_tr[r][c] = LPMIN;
      for (int c = 0; c < NO; c++) r_ob[r][c] = LPMIN;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", int'(busy), 0);
    check(sym_ready == 1'b1, "R1", int'(sym_ready), 1);
    check(score_valid == 1'b0, "R1", int'(score_valid), 0);
    // R1/R5: untouched model scores as impossible
    run_sym(4, 1'b1, 2, 1'b0, 1'b1, "R1");
    check(int'(score) == PMIN, "R1", int'(score), PMIN);

    // R3: single-symbol sequence on a random model
    load_model(1'b1, 0);
    run_sym(9, 1'b1, 6, 1'b0, 1'b1, "R3");
    // R9: next symbol restarts from the start log-probabilities
    run_sym(2, 1'b1, 1, 1'b0, 1'b1, "R9");
    // R4: multi-step recursion
    run_sym(1, 1'b0, 0, 1'b0, 1'b1, "R4");
    run_sym(7, 1'b0, 0, 1'b0, 1'b1, "R4");
    run_sym(12, 1'b1, 3, 1'b0, 1'b1, "R4");
    // R2: kind 3 and out-of-range transition column store nothing
    wr(3, 0, 0, 0);
    wr(1, 2, 11, 0);
    wr(0, 5, 0, -7);
    wr(2, 5, 6, -3);
    run_sym(6, 1'b1, 5, 1'b0, 1'b1, "R2");
    check(int'(score) == -10, "R2", int'(score), -10);
    // R5: impossible emission
    wr(2, 2, 7, LPMIN);
    run_sym(7, 1'b1, 2, 1'b0, 1'b1, "R5");
    check(int'(score) == PMIN, "R5", int'(score), PMIN);
    // R10/R7: symbol and write injected while busy are ignored
    run_sym(3, 1'b0, 5, 1'b0, 1'b0, "R10");
    run_sym(8, 1'b1, 5, 1'b1, 1'b1, "R10");
    run_sym(8, 1'b1, 5, 1'b0, 1'b1, "R10");
    check(sym_ready == 1'b1, "R7", int'(sym_ready), 1);

    // Random models and sequences
    for (int n = 0; n < 25; n++) begin
      int len;
      int fin;
      if (n % 5 == 0) load_model(1'b1, 0);
      len = int'($urandom_range(1, 9));
      fin = int'($urandom_range(0, NS - 1));
      for (int t = 0; t < len; t++)
        run_sym(int'($urandom_range(0, NO - 1)), t == len - 1, fin, 1'b0, 1'b0, "R4");
    end

    // R6: low saturation
    load_model(1'b0, -30000);
    for (int t = 0; t < 150; t++) run_sym(t % NO, t == 149, 4, 1'b0, 1'b0, "R6");
    check(int'(score) == PMIN, "R6", int'(score), PMIN);
    // R6: high saturation
    load_model(1'b0, 30000);
    for (int t = 0; t < 150; t++) run_sym((t * 5) % NO, t == 149, 7, 1'b0, 1'b0, "R6");
    check(int'(score) == PMAX, "R6", int'(score), PMAX);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule